// File: doc/BRIEF.md
# Double-Precision Floating-Point Instruction Decoder

This block takes one 32-bit instruction word per clock and decides whether it is a valid member of the double-precision floating-point group. If it is, the block reports which operation it is, the four register index fields, the rounding mode that applies, and which register file each operand uses. Three configuration inputs shape the legality rules. One says a separate double-precision FPU is present. One says the variant that keeps floating-point values in the integer register file is present. One gives the integer register width. The dynamic rounding mode from the floating-point control register is also an input, used when the instruction asks for it.

When both configurations are enabled, the separate FPU takes precedence. Shared-register mode applies only when the shared variant is on and the separate FPU is off. In that mode, a double value on a 32-bit integer datapath spans two registers, so every operand that carries a double must use an even index. Operands that carry a 32-bit integer or a single-precision value are exempt. All results are registered, so they appear one clock after the word is presented. Loads, stores, single-precision operations and the arithmetic itself lie outside this block.

Top module: `fpd_decode`

## Requirements
- R1: All outputs are registered. The outputs seen after rising edge k describe the inputs sampled at edge k. While rst_ni is low, every output is 0.
- R2: Fused multiply-add is decoded when the opcode is 0x43, 0x47, 0x4B or 0x4F and instruction bits [26:25] are 01. These give op codes 1 (multiply-add), 2 (multiply-subtract), 3 (negated multiply-subtract) and 4 (negated multiply-add). Index rs3 is taken from bits [31:27]. All four registers carry doubles.
- R3: Under opcode 0x53, bits [31:25] equal to 0x01, 0x05, 0x09 or 0x0D give op 5 (add), 6 (subtract), 7 (multiply) or 8 (divide). Bits [31:25] equal to 0x2D with bits [24:20] equal to 0 give op 9 (square root).
- R4: Conversions under opcode 0x53 are decoded from bits [31:25] and the rs2 field, bits [24:20]. With 0x61 and rs2 values 0 to 3, the ops are 10 to 13 (double to signed 32-bit, unsigned 32-bit, signed 64-bit, unsigned 64-bit). With 0x69 and rs2 values 0 to 3, the ops are 14 to 17, converting the same four integer types to double. 0x20 with rs2=1 gives op 18 (double to single). 0x21 with rs2=0 gives op 19 (single to double).
- R5: Under opcode 0x53, with funct3 in bits [14:12]:
  - 0x11 with funct3 0, 1, 2 gives ops 20, 21, 22 (sign copy, sign negate, sign xor).
  - 0x15 with funct3 0, 1 gives ops 23, 24 (min, max).
  - 0x51 with funct3 2, 1, 0 gives ops 25, 26, 27 (equal, less-than, less-or-equal).
  - 0x71 with rs2=0 and funct3=1 gives op 28 (classify).
  - 0x71 with rs2=0 and funct3=0 gives op 29 (raw move double to integer).
  - 0x79 with rs2=0 and funct3=0 gives op 30 (raw move integer to double).
- R6: Any other combination of opcode, bits [31:25], funct3 and rs2 is illegal (illegal_o=1).
- R7: An instruction is illegal when both dfpu_en_i and shared_en_i are 0. Ops 12, 13, 16 and 17 are also illegal when xlen64_i is 0.
- R8: Ops 29 and 30 are illegal when dfpu_en_i is 0, whatever the value of shared_en_i.
- R9: The pair rule applies when shared_en_i=1, dfpu_en_i=0 and xlen64_i=0. Under this rule, an odd index on any operand that carries a double makes the instruction illegal. The checked operands are:
  - ops 1 to 4: all four registers;
  - ops 5 to 8 and 20 to 24: rs1, rs2 and rd;
  - ops 9 and 19: rs1 and rd for op 9, rd only for op 19;
  - ops 10 to 13, 18 and 25 to 29: the double sources only;
  - ops 14 to 17 and 30: rd only.
- R10: Ops 1 to 19 use funct3 as the rounding field. A field of 5 or 6 is illegal. A field of 7 selects dyn_rm_i, and the instruction is then illegal if dyn_rm_i is 5 or above. For a legal instruction that uses rounding, rm_o carries the resolved mode. For every other op, rm_o is 0 and the field is not checked.
- R11: int_file_o is ordered {rd, rs3, rs2, rs1}. A bit is 1 when that operand carries an integer value, or when it carries a floating-point value and shared-register mode is active (shared_en_i=1 and dfpu_en_i=0). Unused operands read 0.
- R12: When illegal_o=1, op_o, rm_o and int_file_o are all 0. rs1_o, rs2_o, rs3_o and rd_o always carry bits [19:15], [24:20], [31:27] and [11:7] of the word, whether or not it is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| insn_i | input | 32 | Instruction word |
| dfpu_en_i | input | 1 | Separate double-precision FPU present |
| shared_en_i | input | 1 | Shared integer-register FP variant present |
| xlen64_i | input | 1 | Integer width is 64 (0 means 32) |
| dyn_rm_i | input | 3 | Dynamic rounding mode from the control register |
| op_o | output | 5 | Operation code, 0 when illegal |
| rs1_o | output | 5 | Source 1 index |
| rs2_o | output | 5 | Source 2 index |
| rs3_o | output | 5 | Source 3 index |
| rd_o | output | 5 | Destination index |
| rm_o | output | 3 | Resolved rounding mode |
| int_file_o | output | 4 | Integer-file flags {rd, rs3, rs2, rs1} |
| illegal_o | output | 1 | Illegal instruction |

## Verification
Rounding-mode rejection and register-pair rejection can strike the same word in the same cycle. A third rule, the width gate on the 64-bit conversions, can add to them. The configuration sweep provokes this overlap by pairing odd register indices with dynamic modes 5 and 7 and with reserved static fields, across all eight configuration combinations. Each such word must raise the single illegal flag, with op, rounding mode and file flags all cleared. The even-index twin of each word must pass or fail on the rounding rule alone.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

  localparam int N_OPND = 4;
  localparam int OP_W   = 5;

  // operand kinds
  localparam logic [1:0] K_NONE = 2'd0;
  localparam logic [1:0] K_DBL  = 2'd1;
  localparam logic [1:0] K_SGL  = 2'd2;
  localparam logic [1:0] K_INT  = 2'd3;

  // major opcodes
  localparam logic [6:0] OPC_MADD  = 7'h43;
  localparam logic [6:0] OPC_MSUB  = 7'h47;
  localparam logic [6:0] OPC_NMSUB = 7'h4B;
  localparam logic [6:0] OPC_NMADD = 7'h4F;
  localparam logic [6:0] OPC_FP    = 7'h53;

  typedef enum logic [OP_W-1:0] {
    OP_NONE   = 5'd0,
    OP_MADD   = 5'd1,  OP_MSUB   = 5'd2,  OP_NMSUB  = 5'd3,  OP_NMADD  = 5'd4,
    OP_ADD    = 5'd5,  OP_SUB    = 5'd6,  OP_MUL    = 5'd7,  OP_DIV    = 5'd8,
    OP_SQRT   = 5'd9,
    OP_D2W    = 5'd10, OP_D2WU   = 5'd11, OP_D2L    = 5'd12, OP_D2LU   = 5'd13,
    OP_W2D    = 5'd14, OP_WU2D   = 5'd15, OP_L2D    = 5'd16, OP_LU2D   = 5'd17,
    OP_D2S    = 5'd18, OP_S2D    = 5'd19,
    OP_SGN    = 5'd20, OP_SGNN   = 5'd21, OP_SGNX   = 5'd22,
    OP_MIN    = 5'd23, OP_MAX    = 5'd24,
    OP_EQ     = 5'd25, OP_LT     = 5'd26, OP_LE     = 5'd27,
    OP_CLASS  = 5'd28, OP_MV_D2X = 5'd29, OP_MV_X2D = 5'd30
  } fpd_op_e;

  typedef struct packed {
    fpd_op_e                 op;
    logic [N_OPND-1:0][1:0]  kind;      // [0]=rs1 [1]=rs2 [2]=rs3 [3]=rd
    logic                    has_rm;
    logic                    need_x64;
    logic                    raw_mv;
    logic                    known;
  } fpd_class_t;

endpackage

// File: rtl/fpd_opc_decode.sv
module fpd_opc_decode
  import fpd_pkg::*;
(
  input  logic [6:0]  opc_i,
  input  logic [2:0]  funct3_i,
  input  logic [6:0]  funct7_i,
  input  logic [4:0]  rs2_i,
  output fpd_class_t  cls_o
);

  logic rs2_zero;
  assign rs2_zero = (rs2_i == 5'd0);

  always_comb begin
    cls_o = '0;
    case (opc_i)
      OPC_MADD, OPC_MSUB, OPC_NMSUB, OPC_NMADD: begin
        if (funct7_i[1:0] == 2'b01) begin
          cls_o.known  = 1'b1;
          cls_o.has_rm = 1'b1;
          cls_o.kind   = {K_DBL, K_DBL, K_DBL, K_DBL};
          case (opc_i)
            OPC_MADD:  cls_o.op = OP_MADD;
            OPC_MSUB:  cls_o.op = OP_MSUB;
            OPC_NMSUB: cls_o.op = OP_NMSUB;
            default:   cls_o.op = OP_NMADD;
          endcase
        end
      end
      OPC_FP: begin
        case (funct7_i)
          7'h01, 7'h05, 7'h09, 7'h0D: begin
            cls_o.known  = 1'b1;
            cls_o.has_rm = 1'b1;
            cls_o.kind   = {K_DBL, K_NONE, K_DBL, K_DBL};
            case (funct7_i[3:2])
              2'd0:    cls_o.op = OP_ADD;
              2'd1:    cls_o.op = OP_SUB;
              2'd2:    cls_o.op = OP_MUL;
              default: cls_o.op = OP_DIV;
            endcase
          end
          7'h2D: begin
            if (rs2_zero) begin
              cls_o.known  = 1'b1;
              cls_o.has_rm = 1'b1;
              cls_o.kind   = {K_DBL, K_NONE, K_NONE, K_DBL};
              cls_o.op     = OP_SQRT;
            end
          end
          7'h61: begin
            if (rs2_i[4:2] == 3'd0) begin
              cls_o.known    = 1'b1;
              cls_o.has_rm   = 1'b1;
              cls_o.need_x64 = rs2_i[1];
              cls_o.kind     = {K_INT, K_NONE, K_NONE, K_DBL};
              case (rs2_i[1:0])
                2'd0:    cls_o.op = OP_D2W;
                2'd1:    cls_o.op = OP_D2WU;
                2'd2:    cls_o.op = OP_D2L;
                default: cls_o.op = OP_D2LU;
              endcase
            end
          end
          7'h69: begin
            if (rs2_i[4:2] == 3'd0) begin
              cls_o.known    = 1'b1;
              cls_o.has_rm   = 1'b1;
              cls_o.need_x64 = rs2_i[1];
              cls_o.kind     = {K_DBL, K_NONE, K_NONE, K_INT};
              case (rs2_i[1:0])
                2'd0:    cls_o.op = OP_W2D;
                2'd1:    cls_o.op = OP_WU2D;
                2'd2:    cls_o.op = OP_L2D;
                default: cls_o.op = OP_LU2D;
              endcase
            end
          end
          7'h20: begin
            if (rs2_i == 5'd1) begin
              cls_o.known  = 1'b1;
              cls_o.has_rm = 1'b1;
              cls_o.kind   = {K_SGL, K_NONE, K_NONE, K_DBL};
              cls_o.op     = OP_D2S;
            end
          end
          7'h21: begin
            if (rs2_zero) begin
              cls_o.known  = 1'b1;
              cls_o.has_rm = 1'b1;
              cls_o.kind   = {K_DBL, K_NONE, K_NONE, K_SGL};
              cls_o.op     = OP_S2D;
            end
          end
          7'h11: begin
            cls_o.kind = {K_DBL, K_NONE, K_DBL, K_DBL};
            case (funct3_i)
              3'd0:    begin cls_o.known = 1'b1; cls_o.op = OP_SGN;  end
              3'd1:    begin cls_o.known = 1'b1; cls_o.op = OP_SGNN; end
              3'd2:    begin cls_o.known = 1'b1; cls_o.op = OP_SGNX; end
              default: cls_o.known = 1'b0;
            endcase
          end
          7'h15: begin
            cls_o.kind = {K_DBL, K_NONE, K_DBL, K_DBL};
            case (funct3_i)
              3'd0:    begin cls_o.known = 1'b1; cls_o.op = OP_MIN; end
              3'd1:    begin cls_o.known = 1'b1; cls_o.op = OP_MAX; end
              default: cls_o.known = 1'b0;
            endcase
          end
          7'h51: begin
            cls_o.kind = {K_INT, K_NONE, K_DBL, K_DBL};
            case (funct3_i)
              3'd2:    begin cls_o.known = 1'b1; cls_o.op = OP_EQ; end
              3'd1:    begin cls_o.known = 1'b1; cls_o.op = OP_LT; end
              3'd0:    begin cls_o.known = 1'b1; cls_o.op = OP_LE; end
              default: cls_o.known = 1'b0;
            endcase
          end
          7'h71: begin
            cls_o.kind = {K_INT, K_NONE, K_NONE, K_DBL};
            if (rs2_zero && funct3_i == 3'd1) begin
              cls_o.known = 1'b1;
              cls_o.op    = OP_CLASS;
            end else if (rs2_zero && funct3_i == 3'd0) begin
              cls_o.known  = 1'b1;
              cls_o.raw_mv = 1'b1;
              cls_o.op     = OP_MV_D2X;
            end
          end
          7'h79: begin
            if (rs2_zero && funct3_i == 3'd0) begin
              cls_o.known  = 1'b1;
              cls_o.raw_mv = 1'b1;
              cls_o.kind   = {K_DBL, K_NONE, K_NONE, K_INT};
              cls_o.op     = OP_MV_X2D;
            end
          end
          default: cls_o = '0;
        endcase
      end
      default: cls_o = '0;
    endcase
    if (!cls_o.known) cls_o = '0;
  end

endmodule

// File: rtl/fpd_rm_resolve.sv
module fpd_rm_resolve #(
  parameter int RM_W = 3
) (
  input  logic            has_rm_i,
  input  logic [RM_W-1:0] field_i,
  input  logic [RM_W-1:0] dyn_i,
  output logic [RM_W-1:0] rm_o,
  output logic            ok_o
);

  localparam logic [RM_W-1:0] RM_DYN     = '1;
  localparam logic [RM_W-1:0] RM_MAX_OK  = RM_W'(4);

  logic [RM_W-1:0] sel;

  always_comb begin
    sel  = (field_i == RM_DYN) ? dyn_i : field_i;
    rm_o = has_rm_i ? sel : '0;
    ok_o = !has_rm_i || (sel <= RM_MAX_OK);
  end

endmodule

// File: rtl/fpd_reg_gate.sv
module fpd_reg_gate
  import fpd_pkg::*;
(
  input  logic [1:0] kind_i,
  input  logic       idx_lsb_i,
  input  logic       shared_i,
  input  logic       x64_i,
  output logic       odd_bad_o,
  output logic       int_o
);

  logic is_dbl, is_fp;

  always_comb begin
    is_dbl    = (kind_i == K_DBL);
    is_fp     = is_dbl || (kind_i == K_SGL);
    odd_bad_o = shared_i && !x64_i && is_dbl && idx_lsb_i;
    int_o     = (kind_i == K_INT) || (shared_i && is_fp);
  end

endmodule

// File: rtl/fpd_decode.sv
module fpd_decode
  import fpd_pkg::*;
#(
  parameter int ILEN   = 32,
  parameter int REG_AW = 5,
  parameter int RM_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ILEN-1:0]   insn_i,
  input  logic              dfpu_en_i,
  input  logic              shared_en_i,
  input  logic              xlen64_i,
  input  logic [RM_W-1:0]   dyn_rm_i,
  output logic [OP_W-1:0]   op_o,
  output logic [REG_AW-1:0] rs1_o,
  output logic [REG_AW-1:0] rs2_o,
  output logic [REG_AW-1:0] rs3_o,
  output logic [REG_AW-1:0] rd_o,
  output logic [RM_W-1:0]   rm_o,
  output logic [N_OPND-1:0] int_file_o,
  output logic              illegal_o
);

  localparam int RD_LO  = 7;
  localparam int F3_LO  = RD_LO + REG_AW;
  localparam int RS1_LO = F3_LO + RM_W;
  localparam int RS2_LO = RS1_LO + REG_AW;
  localparam int F7_LO  = RS2_LO + REG_AW;
  localparam int RS3_LO = F7_LO + 2;

  fpd_class_t            cls;
  logic [RM_W-1:0]       rm_sel;
  logic                  rm_ok;
  logic                  shared_mode;
  logic [N_OPND-1:0]     idx_lsb;
  logic [N_OPND-1:0]     odd_bad;
  logic [N_OPND-1:0]     use_int;
  logic                  legal;

  assign shared_mode = shared_en_i && !dfpu_en_i;
  assign idx_lsb     = {insn_i[RD_LO], insn_i[RS3_LO], insn_i[RS2_LO], insn_i[RS1_LO]};

  fpd_opc_decode u_opc (
    .opc_i    (insn_i[6:0]),
    .funct3_i (insn_i[F3_LO +: RM_W]),
    .funct7_i (insn_i[ILEN-1:F7_LO]),
    .rs2_i    (insn_i[RS2_LO +: REG_AW]),
    .cls_o    (cls)
  );

  fpd_rm_resolve #(.RM_W(RM_W)) u_rm (
    .has_rm_i (cls.has_rm),
    .field_i  (insn_i[F3_LO +: RM_W]),
    .dyn_i    (dyn_rm_i),
    .rm_o     (rm_sel),
    .ok_o     (rm_ok)
  );

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    fpd_reg_gate u_gate (
      .kind_i    (cls.kind[g]),
      .idx_lsb_i (idx_lsb[g]),
      .shared_i  (shared_mode),
      .x64_i     (xlen64_i),
      .odd_bad_o (odd_bad[g]),
      .int_o     (use_int[g])
    );
  end

  assign legal = cls.known
              && (dfpu_en_i || shared_en_i)
              && (!cls.raw_mv || dfpu_en_i)
              && (!cls.need_x64 || xlen64_i)
              && rm_ok
              && !(|odd_bad);

  // next state
  logic [OP_W-1:0]   op_d;
  logic [RM_W-1:0]   rm_d;
  logic [N_OPND-1:0] int_d;

  always_comb begin
    op_d  = legal ? cls.op  : OP_NONE;
    rm_d  = legal ? rm_sel  : '0;
    int_d = legal ? use_int : '0;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o       <= '0;
      rs1_o      <= '0;
      rs2_o      <= '0;
      rs3_o      <= '0;
      rd_o       <= '0;
      rm_o       <= '0;
      int_file_o <= '0;
      illegal_o  <= 1'b0;
    end else begin
      op_o       <= op_d;
      rs1_o      <= insn_i[RS1_LO +: REG_AW];
      rs2_o      <= insn_i[RS2_LO +: REG_AW];
      rs3_o      <= insn_i[RS3_LO +: REG_AW];
      rd_o       <= insn_i[RD_LO +: REG_AW];
      rm_o       <= rm_d;
      int_file_o <= int_d;
      illegal_o  <= !legal;
    end
  end

endmodule

// File: rtl/fpd_decode_chk.sv
module fpd_decode_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] insn_i,
  input logic        dfpu_en_i,
  input logic        shared_en_i,
  input logic        xlen64_i,
  input logic [4:0]  op_o,
  input logic [4:0]  rd_o,
  input logic [2:0]  rm_o,
  input logic [3:0]  int_file_o,
  input logic        illegal_o
);

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  a_r12_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    illegal_o |-> (op_o == 5'd0 && rm_o == 3'd0 && int_file_o == 4'd0));

  a_r1_rd_follows: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    1'b1 |-> rd_o == $past(insn_i[11:7]));

  a_r7_no_ext: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(!dfpu_en_i && !shared_en_i) |-> illegal_o);

  a_r8_raw_move: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(!dfpu_en_i && insn_i[6:0] == 7'h53 && insn_i[14:12] == 3'd0 &&
          insn_i[24:20] == 5'd0 &&
          (insn_i[31:25] == 7'h71 || insn_i[31:25] == 7'h79)) |-> illegal_o);

  a_r9_odd_rd: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(shared_en_i && !dfpu_en_i && !xlen64_i && insn_i[7] &&
          insn_i[6:0] == 7'h43) |-> illegal_o);

  a_r10_static_rm: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(insn_i[6:0] == 7'h4F && insn_i[14:12] == 3'd6) |-> illegal_o);

  a_r10_rm_range: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !illegal_o |-> rm_o <= 3'd4);

endmodule

bind fpd_decode fpd_decode_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .insn_i      (insn_i),
  .dfpu_en_i   (dfpu_en_i),
  .shared_en_i (shared_en_i),
  .xlen64_i    (xlen64_i),
  .op_o        (op_o),
  .rd_o        (rd_o),
  .rm_o        (rm_o),
  .int_file_o  (int_file_o),
  .illegal_o   (illegal_o)
);

// File: tb/tb_fpd_decode.sv
`timescale 1ns/1ps
module tb_fpd_decode;

  localparam int WD_CYCLES = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [31:0] insn_i;
  logic        dfpu_en_i, shared_en_i, xlen64_i;
  logic [2:0]  dyn_rm_i;
  logic [4:0]  op_o, rs1_o, rs2_o, rs3_o, rd_o;
  logic [2:0]  rm_o;
  logic [3:0]  int_file_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  fpd_decode dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .insn_i(insn_i),
    .dfpu_en_i(dfpu_en_i), .shared_en_i(shared_en_i), .xlen64_i(xlen64_i),
    .dyn_rm_i(dyn_rm_i), .op_o(op_o), .rs1_o(rs1_o), .rs2_o(rs2_o),
    .rs3_o(rs3_o), .rd_o(rd_o), .rm_o(rm_o), .int_file_o(int_file_o),
    .illegal_o(illegal_o)
  );

  // reference model written from the requirements
  function automatic logic [32:0] ref_dec(input logic [31:0] w, input logic d,
                                          input logic s, input logic x,
                                          input logic [2:0] dyn);
    logic [6:0] opc, f7;
    logic [2:0] f3, eff, rmv;
    logic [4:0] r2, opv;
    int op, k1, k2, k3, kd;
    bit rmu, n64, raw, sh, oddb, ill;
    logic [3:0] fl;
    opc = w[6:0]; f7 = w[31:25]; f3 = w[14:12]; r2 = w[24:20];
    op = 0; k1 = 0; k2 = 0; k3 = 0; kd = 0; rmu = 0; n64 = 0; raw = 0;
    if ((opc == 7'h43 || opc == 7'h47 || opc == 7'h4B || opc == 7'h4F) && w[26:25] == 2'b01) begin
      op = 1 + int'(opc - 7'h43) / 4; k1 = 1; k2 = 1; k3 = 1; kd = 1; rmu = 1;
    end else if (opc == 7'h53) begin
      if (f7 == 7'h01 || f7 == 7'h05 || f7 == 7'h09 || f7 == 7'h0D) begin
        op = 5 + int'(f7[3:2]); k1 = 1; k2 = 1; kd = 1; rmu = 1;
      end else if (f7 == 7'h2D && r2 == 0) begin
        op = 9; k1 = 1; kd = 1; rmu = 1;
      end else if (f7 == 7'h61 && r2 < 4) begin
        op = 10 + int'(r2); k1 = 1; kd = 3; rmu = 1; n64 = (r2 >= 2);
      end else if (f7 == 7'h69 && r2 < 4) begin
        op = 14 + int'(r2); k1 = 3; kd = 1; rmu = 1; n64 = (r2 >= 2);
      end else if (f7 == 7'h20 && r2 == 1) begin
        op = 18; k1 = 1; kd = 2; rmu = 1;
      end else if (f7 == 7'h21 && r2 == 0) begin
        op = 19; k1 = 2; kd = 1; rmu = 1;
      end else if (f7 == 7'h11 && f3 < 3) begin
        op = 20 + int'(f3); k1 = 1; k2 = 1; kd = 1;
      end else if (f7 == 7'h15 && f3 < 2) begin
        op = 23 + int'(f3); k1 = 1; k2 = 1; kd = 1;
      end else if (f7 == 7'h51 && f3 < 3) begin
        op = 27 - int'(f3); k1 = 1; k2 = 1; kd = 3;
      end else if (f7 == 7'h71 && r2 == 0 && f3 == 1) begin
        op = 28; k1 = 1; kd = 3;
      end else if (f7 == 7'h71 && r2 == 0 && f3 == 0) begin
        op = 29; k1 = 1; kd = 3; raw = 1;
      end else if (f7 == 7'h79 && r2 == 0 && f3 == 0) begin
        op = 30; k1 = 3; kd = 1; raw = 1;
      end
    end
    eff = (f3 == 3'd7) ? dyn : f3;
    sh = s && !d;
    oddb = sh && !x && ((k1 == 1 && w[15]) || (k2 == 1 && w[20]) ||
                        (k3 == 1 && w[27]) || (kd == 1 && w[7]));
    fl[0] = (k1 == 3) || (sh && (k1 == 1 || k1 == 2));
    fl[1] = (k2 == 3) || (sh && (k2 == 1 || k2 == 2));
    fl[2] = (k3 == 3) || (sh && (k3 == 1 || k3 == 2));
    fl[3] = (kd == 3) || (sh && (kd == 1 || kd == 2));
    ill = (op == 0) || !(d || s) || (raw && !d) || (n64 && !x) ||
          (rmu && eff > 3'd4) || oddb;
    rmv = rmu ? eff : 3'd0;
    opv = 5'(op);
    if (ill) begin opv = 0; rmv = 0; fl = 0; end
    return {opv, w[19:15], w[24:20], w[31:27], w[11:7], rmv, fl, ill};
  endfunction

  // scoreboard
  logic [32:0] exp_q[$];
  logic [31:0] w_q[$];
  string       tag_q[$];

  task automatic drive(input logic [31:0] w, input logic d, input logic s,
                       input logic x, input logic [2:0] dyn, input string tag);
    @(negedge clk_i);
    insn_i = w; dfpu_en_i = d; shared_en_i = s; xlen64_i = x; dyn_rm_i = dyn;
    exp_q.push_back(ref_dec(w, d, s, x, dyn));
    w_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk_i) begin
    #1;
    if (rst_ni && exp_q.size() > 0) begin
      logic [32:0] e, a;
      logic [31:0] w;
      string t;
      e = exp_q.pop_front(); w = w_q.pop_front(); t = tag_q.pop_front();
      a = {op_o, rs1_o, rs2_o, rs3_o, rd_o, rm_o, int_file_o, illegal_o};
      n_chk++;
      if (a !== e) begin
        n_err++;
        $display("FAIL %s insn=%h actual=%h expected=%h", t, w, a, e);
      end
    end
  end

  localparam logic [6:0] F7S [14] = '{7'h01, 7'h05, 7'h09, 7'h0D, 7'h2D, 7'h61, 7'h69,
                                      7'h20, 7'h21, 7'h11, 7'h15, 7'h51, 7'h71, 7'h79};
  localparam logic [6:0] FMA_OPC [4] = '{7'h43, 7'h47, 7'h4B, 7'h4F};

  initial begin
    rst_ni = 1'b0;
    insn_i = 32'h0220_F2C3; dfpu_en_i = 1'b1; shared_en_i = 1'b0;
    xlen64_i = 1'b1; dyn_rm_i = 3'd0;
    repeat (3) @(posedge clk_i);
    #1;
    n_chk++;
    if ({op_o, rs1_o, rs2_o, rs3_o, rd_o, rm_o, int_file_o, illegal_o} !== 33'd0) begin
      n_err++;
      $display("FAIL R1 reset actual=%h expected=0",
               {op_o, rs1_o, rs2_o, rs3_o, rd_o, rm_o, int_file_o, illegal_o});
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 R4 R5 R6 R12: full funct7/funct3/rs2 sweep under the FP opcode
    for (int f7 = 0; f7 < 128; f7++)
      for (int f3 = 0; f3 < 8; f3++)
        for (int r2 = 0; r2 < 32; r2++)
          drive({7'(f7), 5'(r2), 5'd3, 3'(f3), 5'd6, 7'h53}, 1'b1, 1'b0, 1'b1, 3'd0,
                "R3/R4/R5/R6/R12");

    // R2 R9 R10: fused forms, all formats, rounding fields and configurations
    for (int o = 0; o < 4; o++)
      for (int fm = 0; fm < 4; fm++)
        for (int f3 = 0; f3 < 8; f3++)
          for (int cfg = 0; cfg < 8; cfg++)
            for (int odd = 0; odd < 2; odd++)
              drive({(odd != 0) ? 5'd7 : 5'd6, 2'(fm), 5'd4, 5'd2, 3'(f3),
                     (odd != 0) ? 5'd9 : 5'd8, FMA_OPC[o]},
                    cfg[0], cfg[1], cfg[2], (f3 == 7) ? 3'd5 : 3'd1, "R2/R9/R10");

    // R7 R8 R9 R10 R11: configuration and dynamic-mode sweep
    for (int i = 0; i < 14; i++)
      for (int f3 = 0; f3 < 8; f3++)
        for (int r2 = 0; r2 < 4; r2++)
          for (int cfg = 0; cfg < 8; cfg++)
            for (int dm = 0; dm < 3; dm++)
              for (int odd = 0; odd < 2; odd++)
                drive({F7S[i], 5'(r2), (odd != 0) ? 5'd3 : 5'd2, 3'(f3),
                       (odd != 0) ? 5'd5 : 5'd4, 7'h53},
                      cfg[0], cfg[1], cfg[2], (dm == 0) ? 3'd0 : (dm == 1) ? 3'd7 : 3'd5,
                      "R7/R8/R9/R10/R11");

    // R6 R11 R12: random words and configurations
    for (int n = 0; n < 8000; n++) begin
      logic [31:0] w;
      w = $urandom;
      if (n % 2 == 0) w[6:0] = 7'h53;
      drive(w, 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom), "R6/R11/R12");
    end

    repeat (4) @(posedge clk_i);
    #2;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(WD_CYCLES * 10);
    if (!finished) begin
      finished = 1'b1;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule